// File: doc/BRIEF.md
# Trail Trace Message Byte Sequencer

This block stores a sixteen-byte path identifier in host-writable byte registers. It hands one of those bytes to the transmit framer for every outgoing frame, to be placed in the frame's trail-trace overhead byte. Sixteen frames in a row form one trace super-frame. Slot 0 goes out in the first frame, slot 1 in the second, and so on up to slot 15. After slot 15 the walk starts again at slot 0 and repeats for as long as frames arrive.

Slot 0 opens the super-frame. Its top bit is a start marker, and its low seven bits are a CRC-7 that host software computes over the previous super-frame. The block never computes that CRC; it sends the byte exactly as written. Slots 1 to 15 normally hold printable characters with a clear top bit. The block stores every in-window write unchanged. When a write puts the marker bit in the wrong state, the block also raises a sticky flag, which any host read clears. The framer pulses `frame_start` once per frame and picks up `tr_byte` and `tr_index` from the following cycle.

Top module: `trail_id_sequencer`

## Requirements
- R1: The sixteen slots sit at host addresses 0x38 (slot 0) to 0x47 (slot 15), one address per slot in ascending order. A write with `host_wr` high stores `host_wdata` in the addressed slot. A read with `host_rd` high puts that slot's byte on `host_rdata` in the following cycle. `host_rdata` is 0x00 in any cycle that follows a cycle without a read.
- R2: Writes to addresses outside 0x38..0x47 change no slot and do not raise the flag. Reads there return 0x00.
- R3: At each clock edge where `frame_start` is high, the block loads the byte of the current slot into `tr_byte` and the slot number into `tr_index`, both valid from the next cycle. The current slot then advances by one. The byte goes out bit for bit as written, CRC bits included.
- R4: The slot after 15 is 0, so every run of 16 consecutive frames carries slots 0 to 15 in order.
- R5: `tr_byte` and `tr_index` stay unchanged in every cycle that does not follow a `frame_start` edge.
- R6: A write at the same edge as the `frame_start` that selects that slot does not affect the byte sent at that edge. The new value goes out the next time the slot is selected.
- R7: A write of slot 0 with bit 7 = 0, or of any slot 1..15 with bit 7 = 1, sets `marker_err` from the next cycle. The byte is still stored as written.
- R8: `marker_err` stays set until a host read at any address, and it is low from the cycle after that read. If a read and a marker-violating write happen at the same edge, the flag stays set.
- R9: While `rst` is high at a clock edge (synchronous, active high), every slot is cleared to 0x00, the current slot becomes 0, `tr_byte`/`tr_index` become 0, and `marker_err` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Read data, valid the cycle after `host_rd` |
| frame_start | input | 1 | One-cycle pulse per outgoing frame |
| tr_byte | output | 8 | Trace byte for the current frame |
| tr_index | output | 4 | Slot number of `tr_byte` within the super-frame |
| marker_err | output | 1 | Sticky marker-misuse flag |

## Verification
The bench runs more than a full super-frame so that the 15-to-0 turnover is crossed. A design that wrapped at the wrong count, or that left a slot out, would give a wrong byte/index pair in the scoreboard. It writes a slot at the same edge as the frame that samples it, and then sends fifteen more frames so the slot comes up again. A design that passed the write straight through would send the new byte one super-frame too early. The bench writes both marker polarities and issues a read at the same edge as a violating write. This catches a flag that is not sticky, one that is not cleared by a read, or one where the clear beats the set. It also probes the addresses just below and just above the window, which catches an off-by-one in address decode that would alias slot 0 or slot 15.

// File: rtl/trail_id_pkg.sv
package trail_id_pkg;
  localparam int MSG_LEN   = 16;
  localparam int SLOT_W    = $clog2(MSG_LEN);
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 8;
  localparam logic [ADDR_W-1:0] BASE_ADDR = 8'h38;
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(MSG_LEN - 1);
  localparam int MARK_BIT  = BYTE_W - 1;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // address lies inside the message window
  function automatic logic in_window(addr_t a);
    return (a >= BASE_ADDR) && (a <= LAST_ADDR);
  endfunction

  // slot number for an in-window address
  function automatic slot_t slot_of(addr_t a);
    addr_t d;
    d = a - BASE_ADDR;
    return d[SLOT_W-1:0];
  endfunction

  // next slot, wrapping at the super-frame length
  function automatic slot_t next_slot(slot_t s);
    slot_t r;
    if (int'(s) == MSG_LEN - 1) r = '0;
    else                        r = s + slot_t'(1);
    return r;
  endfunction

  // marker rule: only slot 0 carries the top bit set
  function automatic logic marker_ok(slot_t s, byte_t b);
    return (s == '0) ? b[MARK_BIT] : !b[MARK_BIT];
  endfunction
endpackage

// File: rtl/tid_regfile.sv
module tid_regfile
  import trail_id_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  addr_t                    host_addr,
  input  byte_t                    host_wdata,
  input  logic                     host_wr,
  input  logic                     host_rd,
  output byte_t                    host_rdata,
  output logic [MSG_LEN*BYTE_W-1:0] msg_flat,
  output logic                     wr_hit,
  output logic                     bad_marker_wr
);
  logic  hit;
  slot_t wslot;
  byte_t rd_mux;
  byte_t rdata_q;
  byte_t slot_q [MSG_LEN];

  always_comb begin
    hit           = in_window(host_addr);
    wslot         = slot_of(host_addr);
    wr_hit        = host_wr && hit;
    bad_marker_wr = wr_hit && !marker_ok(wslot, host_wdata);
    rd_mux        = hit ? slot_q[wslot] : '0;
  end

  for (genvar g = 0; g < MSG_LEN; g++) begin : g_slot
    logic we;
    assign we = wr_hit && (wslot == slot_t'(g));
    always_ff @(posedge clk) begin
      if (rst)     slot_q[g] <= '0;
      else if (we) slot_q[g] <= host_wdata;
    end
    assign msg_flat[g*BYTE_W +: BYTE_W] = slot_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (host_rd) rdata_q <= rd_mux;
    else              rdata_q <= '0;
  end

  assign host_rdata = rdata_q;
endmodule

// File: rtl/tid_sequencer.sv
module tid_sequencer
  import trail_id_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_start,
  input  logic [MSG_LEN*BYTE_W-1:0] msg_flat,
  output byte_t                     tr_byte,
  output slot_t                     tr_index,
  output slot_t                     seq_ptr,
  output logic                      frame_take
);
  slot_t ptr_q;
  byte_t byte_q;
  slot_t idx_q;
  byte_t sel_byte;

  always_comb begin
    sel_byte   = msg_flat[int'(ptr_q)*BYTE_W +: BYTE_W];
    frame_take = frame_start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      byte_q <= '0;
      idx_q  <= '0;
    end else if (frame_take) begin
      byte_q <= sel_byte;
      idx_q  <= ptr_q;
      ptr_q  <= next_slot(ptr_q);
    end
  end

  assign tr_byte  = byte_q;
  assign tr_index = idx_q;
  assign seq_ptr  = ptr_q;
endmodule

// File: rtl/tid_marker_flag.sv
module tid_marker_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_evt) flag_q <= 1'b0;
  end

  assign flag = flag_q;
endmodule

// File: rtl/trail_id_sequencer.sv
module trail_id_sequencer
  import trail_id_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] host_addr,
  input  logic [7:0] host_wdata,
  input  logic       host_wr,
  input  logic       host_rd,
  output logic [7:0] host_rdata,
  input  logic       frame_start,
  output logic [7:0] tr_byte,
  output logic [3:0] tr_index,
  output logic       marker_err
);
  logic [MSG_LEN*BYTE_W-1:0] msg_flat;
  logic  wr_hit;
  logic  bad_marker_wr;
  slot_t seq_ptr;
  logic  frame_take;

  tid_regfile u_regs (
    .clk           (clk),
    .rst           (rst),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_rdata    (host_rdata),
    .msg_flat      (msg_flat),
    .wr_hit        (wr_hit),
    .bad_marker_wr (bad_marker_wr)
  );

  tid_sequencer u_seq (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .msg_flat    (msg_flat),
    .tr_byte     (tr_byte),
    .tr_index    (tr_index),
    .seq_ptr     (seq_ptr),
    .frame_take  (frame_take)
  );

  tid_marker_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .set_evt (bad_marker_wr),
    .clr_evt (host_rd),
    .flag    (marker_err)
  );
endmodule

// File: rtl/tid_checker.sv
module tid_checker
  import trail_id_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [7:0] host_addr,
  input logic       host_rd,
  input logic [7:0] host_rdata,
  input logic       frame_start,
  input logic [7:0] tr_byte,
  input logic [3:0] tr_index,
  input logic       marker_err,
  input logic       bad_marker_wr,
  input slot_t      seq_ptr
);
  // index sent equals the slot that was current at the pulse
  assert_index_follows_ptr_R3: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (tr_index == $past(seq_ptr)));

  // slot advances by one and wraps after the last
  assert_ptr_wraps_R4: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (seq_ptr == (($past(seq_ptr) == slot_t'(MSG_LEN-1)) ? '0 : $past(seq_ptr) + slot_t'(1))));

  // outputs hold between pulses
  assert_outputs_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(tr_byte) && $stable(tr_index)));

  // pointer only moves on a pulse
  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(seq_ptr));

  // violating write raises the flag
  assert_flag_sets_R7: assert property (@(posedge clk) disable iff (rst)
    bad_marker_wr |=> marker_err);

  // read without a violation clears the flag
  assert_flag_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !bad_marker_wr) |=> !marker_err);

  // flag is sticky without a read
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (marker_err && !host_rd) |=> marker_err);

  // out-of-window read returns zero
  assert_outside_read_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !in_window(host_addr)) |=> (host_rdata == 8'h00));

  // reset state
  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (tr_index == 4'd0 && tr_byte == 8'h00 && !marker_err && seq_ptr == '0));
endmodule

bind trail_id_sequencer tid_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .host_addr     (host_addr),
  .host_rd       (host_rd),
  .host_rdata    (host_rdata),
  .frame_start   (frame_start),
  .tr_byte       (tr_byte),
  .tr_index      (tr_index),
  .marker_err    (marker_err),
  .bad_marker_wr (bad_marker_wr),
  .seq_ptr       (seq_ptr)
);

// File: tb/sim_trail_id_sequencer.sv
`timescale 1ns/1ps
module sim_trail_id_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic       frame_start = 1'b0;
  logic [7:0] tr_byte;
  logic [3:0] tr_index;
  logic       marker_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] mdl_mem [16];
  int         mdl_ptr = 0;
  logic [11:0] sb_q [$];   // {index, byte}

  always #2 clk = ~clk;    // 250 MHz

  trail_id_sequencer u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .frame_start(frame_start), .tr_byte(tr_byte), .tr_index(tr_index),
    .marker_err(marker_err)
  );

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mdl_clear();
    for (int i = 0; i < 16; i++) mdl_mem[i] = 8'h00;
    mdl_ptr = 0;
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    if (a >= 8'h38 && a <= 8'h47) mdl_mem[a - 8'h38] = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic do_read(logic [7:0] a, string req);
    logic [7:0] exp;
    exp = (a >= 8'h38 && a <= 8'h47) ? mdl_mem[a - 8'h38] : 8'h00;
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    check(req, host_rdata, exp);
  endtask

  // driver: pulses a frame and pushes the expected result
  task automatic pulse_frame(bit with_wr = 0, logic [7:0] wdat = 8'h00);
    @(negedge clk);
    sb_q.push_back({4'(mdl_ptr), mdl_mem[mdl_ptr]});
    if (with_wr) begin
      host_addr = 8'h38 + 8'(mdl_ptr); host_wdata = wdat; host_wr = 1'b1;
      mdl_mem[mdl_ptr] = wdat;
    end
    mdl_ptr = (mdl_ptr + 1) % 16;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    host_wr = 1'b0;
  endtask

  // monitor: compares design output after each pulse
  always begin
    @(posedge clk);
    if (frame_start && !rst) begin
      @(negedge clk);
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R3: actual output with empty scoreboard, expected none");
      end else begin
        logic [11:0] e;
        e = sb_q.pop_front();
        check("R3/R4 index", tr_index, e[11:8]);
        check("R3/R6 byte", tr_byte, e[7:0]);
      end
    end
  end

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] hold_b;
    logic [3:0] hold_i;
    mdl_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 tr_byte", tr_byte, 0);
    check("R9 tr_index", tr_index, 0);
    check("R9 flag", marker_err, 0);
    do_read(8'h38, "R9 slot0");

    // R1 fill and read back
    do_write(8'h38, 8'hB5);
    for (int i = 1; i < 16; i++) do_write(8'h38 + 8'(i), 8'h41 + 8'(i));
    check("R7 no flag on legal writes", marker_err, 0);
    for (int i = 0; i < 16; i++) do_read(8'h38 + 8'(i), "R1 readback");

    // R2 outside window
    do_write(8'h37, 8'hFF);
    do_write(8'h48, 8'h7E);
    check("R2 no flag outside", marker_err, 0);
    do_read(8'h37, "R2 read below");
    do_read(8'h48, "R2 read above");
    do_read(8'h38, "R2 slot0 untouched");
    do_read(8'h47, "R2 slot15 untouched");

    // R3/R4 twenty frames crossing the wrap
    for (int i = 0; i < 20; i++) begin
      pulse_frame();
      if (i % 5 == 0) repeat (3) @(negedge clk);
    end
    // R5 hold between pulses
    hold_b = tr_byte; hold_i = tr_index;
    repeat (6) @(negedge clk);
    check("R5 byte hold", tr_byte, hold_b);
    check("R5 index hold", tr_index, hold_i);

    // R6 write coinciding with the frame that samples the slot
    pulse_frame(1'b1, 8'h5A);
    for (int i = 0; i < 15; i++) pulse_frame();
    repeat (2) @(negedge clk);

    // R7/R8 marker misuse
    do_write(8'h38, 8'h12);
    check("R7 slot0 clear marker", marker_err, 1);
    repeat (4) @(negedge clk);
    check("R8 sticky", marker_err, 1);
    do_read(8'h40, "R1 read during flag");
    check("R8 cleared by read", marker_err, 0);
    do_write(8'h3D, 8'hC1);
    check("R7 slot5 set marker", marker_err, 1);
    do_read(8'h3D, "R7 stored as written");
    check("R8 cleared again", marker_err, 0);
    // simultaneous read and violating write: set wins
    @(negedge clk);
    host_addr = 8'h3E; host_wdata = 8'h90; host_wr = 1'b1; host_rd = 1'b1;
    mdl_mem[6] = 8'h90;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    check("R8 set beats clear", marker_err, 1);
    do_read(8'h4F, "R2 read outside clears");
    check("R8 clear by outside read", marker_err, 0);

    // frames carry the bad-marker bytes unchanged
    for (int i = 0; i < 16; i++) pulse_frame();
    repeat (2) @(negedge clk);

    // R9 reset mid-run
    do_write(8'h38, 8'h30);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    mdl_clear();
    check("R9 index after reset", tr_index, 0);
    check("R9 byte after reset", tr_byte, 0);
    check("R9 flag after reset", marker_err, 0);
    do_read(8'h3D, "R9 slot cleared");
    pulse_frame();
    pulse_frame();
    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", sb_q.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule